// File: doc/BRIEF.md
# Inhibitable Periodic Reload Timer

This block is one programmable interval timer for an interrupt controller. Software controls it through a single base count register. The most significant bit of that register is an inhibit flag, and the remaining bits give the reload period in ticks. When the flag is clear, the timer counts down by one on every cycle where the tick enable is high. When the count expires, the timer emits a one-cycle interrupt pulse and reloads itself from the base count to start the next period.

A read-only current count port reports the live count. While the timer runs, this is the number of ticks left until expiry. While it is inhibited, this is the value frozen at the moment it was stopped. A start never resumes a frozen count. It always loads the period given in the same write. A write that leaves the inhibit state unchanged changes only the stored base, so it takes effect at the next reload.

Top module: `inhibit_reload_timer`

## Requirements
- R1: Out of reset the base count reads 0x80000000 (inhibit set), the current count reads 0 and the interrupt is low. Ticks do not change the current count until a start write.
- R2: A write with bit 31 clear while the timer is inhibited starts it. On the next cycle the current count equals bits 30:0 of the written value, and the timer is running.
- R3: A write with bit 31 set while the timer is running stops it. The current count keeps the value it had before that write, and later ticks leave it unchanged.
- R4: A write whose bit 31 matches the present inhibit state updates only the base count. A running count keeps decrementing and a frozen count stays frozen.
- R5: While running, each cycle with tick high and a count other than 1 lowers the current count by exactly one. A cycle with tick low leaves it unchanged.
- R6: While running, a tick with the count at 1 makes the interrupt output high for exactly that following cycle, and the count reloads with bits 30:0 of the base count. If a same-state write lands in that cycle, the written value is used.
- R7: The base count port returns the last value written, bit 31 included, from the cycle after the write.
- R8: A start with period zero counts as 2^31 ticks. The first tick moves the count to 0x7FFFFFFF without raising the interrupt.
- R9: In a cycle carrying a start or stop write, a simultaneous tick does not decrement the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the base count register |
| wr_data | input | DATA_W | Written value; the top bit is the inhibit flag |
| tick | input | 1 | Count enable, one decrement per high cycle |
| base_rd | output | DATA_W | Base count register readback |
| cur_rd | output | DATA_W-1 | Current count readback |
| irq | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
The hardest case to reach is a write that arrives in the same cycle as an expiry or a tick. Examples are a same-state write landing exactly when the count hits 1, and a stop or start write that coincides with a tick. Reaching these cases needs the write strobe aligned with the count's last step. Directed sequences place them deliberately. Random stimulus then uses mostly short periods (0 to 9 ticks) with frequent writes and ticks, so these alignments recur many times. A bench model derived from the requirements tracks the expected state on every cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
   // Classification of a base count write against the present run state
   typedef enum logic [1:0] {
      WR_NONE  = 2'd0,
      WR_START = 2'd1,
      WR_STOP  = 2'd2,
      WR_KEEP  = 2'd3
   } wr_kind_e;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
   import timer_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] base_q,
   output logic              run_q,
   output wr_kind_e          kind
);
   localparam int FLAG = DATA_W - 1;
   localparam logic [DATA_W-1:0] BASE_RST = {1'b1, {(DATA_W-1){1'b0}}};

   always_comb begin
      if (!wr_en)                          kind = WR_NONE;
      else if (!run_q && !wr_data[FLAG])   kind = WR_START;
      else if (run_q && wr_data[FLAG])     kind = WR_STOP;
      else                                 kind = WR_KEEP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= BASE_RST;
         run_q  <= 1'b0;
      end else begin
         if (wr_en) base_q <= wr_data;
         if (kind == WR_START)     run_q <= 1'b1;
         else if (kind == WR_STOP) run_q <= 1'b0;
      end
   end

   p_base_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> base_q == $past(wr_data));
   p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == WR_START) |=> run_q);
   p_stop_halts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == WR_STOP) |=> !run_q);
   p_keep_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == WR_KEEP) |=> $stable(run_q));
endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
   parameter int CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val,
   input  logic             advance_i,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count_q,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   assign expire_o = advance_i && (count_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)         count_q <= '0;
      else if (load_i)    count_q <= load_val;
      else if (expire_o)  count_q <= reload_val;
      else if (advance_i) count_q <= count_q - ONE;
   end

   p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (advance_i && !load_i && count_q != ONE) |=> count_q == $past(count_q) - ONE);
   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !load_i) |=> count_q == $past(reload_val));
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !advance_i) |=> $stable(count_q));
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> count_q == $past(load_val));
endmodule

// File: rtl/tmr_irq_stage.sv
module tmr_irq_stage #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   output logic irq_o
);
   generate
      if (REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= expire_i;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         assign irq_o = expire_i;
      end
   endgenerate
endmodule

// File: rtl/inhibit_reload_timer.sv
module inhibit_reload_timer
   import timer_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick,
   output logic [DATA_W-1:0] base_rd,
   output logic [DATA_W-2:0] cur_rd,
   output logic              irq
);
   localparam int CNT_W = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("inhibit_reload_timer: DATA_W must be at least 2");
      end
   endgenerate

   wr_kind_e         kind;
   logic             run_q;
   logic [DATA_W-1:0] base_q;
   logic             load;
   logic             advance;
   logic             expire;
   logic [CNT_W-1:0] reload_val;
   logic [CNT_W-1:0] count_q;

   tmr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .base_q  (base_q),
      .run_q   (run_q),
      .kind    (kind)
   );

   // Start and stop writes take the cycle; a same-state write lets the count move on.
   assign load       = (kind == WR_START);
   assign advance    = run_q && tick && (kind != WR_STOP) && (kind != WR_START);
   assign reload_val = (kind == WR_KEEP) ? wr_data[CNT_W-1:0] : base_q[CNT_W-1:0];

   tmr_down #(.CNT_W(CNT_W)) u_down (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val   (wr_data[CNT_W-1:0]),
      .advance_i  (advance),
      .reload_val (reload_val),
      .count_q    (count_q),
      .expire_o   (expire)
   );

   tmr_irq_stage #(.REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire_i (expire),
      .irq_o    (irq)
   );

   assign base_rd = base_q;
   assign cur_rd  = count_q;

   p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && kind != WR_START) |=> $stable(cur_rd));
   p_tick_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == WR_STOP) |=> cur_rd == $past(cur_rd));

   generate
      if (IRQ_REGISTERED) begin : g_chk_reg
         p_irq_running_r6: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> $past(run_q && tick));
         p_irq_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> cur_rd == $past(reload_val));
      end
   endgenerate
endmodule

// File: tb/inhibit_reload_timer_test.sv
module inhibit_reload_timer_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int CW = DW - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          tick = 1'b0;
   logic [DW-1:0] base_rd;
   logic [CW-1:0] cur_rd;
   logic          irq;

   int checks = 0;
   int errors = 0;

   // requirement-level model state
   logic          m_run;
   logic [DW-1:0] m_base;
   logic [CW-1:0] m_cnt;
   logic          m_irq;

   inhibit_reload_timer #(.DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tick(tick), .base_rd(base_rd), .cur_rd(cur_rd), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] next_count(input logic run, input logic [CW-1:0] cnt,
                                                input logic tk, input logic [CW-1:0] reload);
      if (!run || !tk)  return cnt;
      if (cnt == 1)     return reload;
      return cnt - 1'b1;
   endfunction

   task automatic model_step(input logic we, input logic [DW-1:0] d, input logic tk);
      logic start, stop;
      start = we && !m_run && !d[DW-1];
      stop  = we && m_run && d[DW-1];
      m_irq = 1'b0;
      if (start) begin
         m_run = 1'b1;
         m_cnt = d[CW-1:0];
      end else if (stop) begin
         m_run = 1'b0;
      end else begin
         if (m_run && tk && m_cnt == 1) m_irq = 1'b1;
         m_cnt = next_count(m_run, m_cnt, tk, we ? d[CW-1:0] : m_base[CW-1:0]);
      end
      if (we) m_base = d;
   endtask

   task automatic compare_all(input string req);
      chk(req, "cur", {1'b0, cur_rd}, {1'b0, m_cnt});
      chk(req, "base", base_rd, m_base);
      chk(req, "irq", {31'd0, irq}, {31'd0, m_irq});
   endtask

   // called at a negedge; returns at the following negedge after checking
   task automatic cycle(input logic we, input logic [DW-1:0] d, input logic tk, input string req);
      wr_en = we; wr_data = d; tick = tk;
      @(posedge clk);
      model_step(we, d, tk);
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
      compare_all(req);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      m_run = 1'b0; m_base = 32'h8000_0000; m_cnt = '0; m_irq = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, ticks ignored while inhibited
      chk("R1", "base reset", base_rd, 32'h8000_0000);
      chk("R1", "cur reset", {1'b0, cur_rd}, 32'd0);
      chk("R1", "irq reset", {31'd0, irq}, 32'd0);
      repeat (3) cycle(1'b0, '0, 1'b1, "R1");
      // R2/R9: start with a tick in the same cycle
      cycle(1'b1, 32'd5, 1'b1, "R2");
      chk("R9", "start ignores tick", {1'b0, cur_rd}, 32'd5);
      // R5: decrement and hold
      repeat (4) cycle(1'b0, '0, 1'b1, "R5");
      chk("R5", "count at one", {1'b0, cur_rd}, 32'd1);
      cycle(1'b0, '0, 1'b0, "R5");
      // R6: expiry and reload
      cycle(1'b0, '0, 1'b1, "R6");
      chk("R6", "irq on expiry", {31'd0, irq}, 32'd1);
      chk("R6", "reload", {1'b0, cur_rd}, 32'd5);
      cycle(1'b0, '0, 1'b1, "R6");
      chk("R6", "irq one cycle", {31'd0, irq}, 32'd0);
      // R4: same-state write while running
      cycle(1'b1, 32'd3, 1'b1, "R4");
      chk("R4", "count continues", {1'b0, cur_rd}, 32'd3);
      repeat (3) cycle(1'b0, '0, 1'b1, "R6");
      chk("R6", "reload new base", {1'b0, cur_rd}, 32'd3);
      // R3/R9/R7: stop with tick, then frozen
      cycle(1'b1, 32'h8000_0009, 1'b1, "R3");
      chk("R9", "stop ignores tick", {1'b0, cur_rd}, 32'd3);
      chk("R7", "base with flag", base_rd, 32'h8000_0009);
      repeat (4) cycle(1'b0, '0, 1'b1, "R3");
      chk("R3", "frozen", {1'b0, cur_rd}, 32'd3);
      // R4: same-state write while stopped
      cycle(1'b1, 32'h8000_0007, 1'b1, "R4");
      chk("R4", "still frozen", {1'b0, cur_rd}, 32'd3);
      chk("R7", "base updated", base_rd, 32'h8000_0007);
      // R8: zero period
      cycle(1'b1, 32'd0, 1'b0, "R8");
      cycle(1'b0, '0, 1'b1, "R8");
      chk("R8", "zero wraps", {1'b0, cur_rd}, 32'h7FFF_FFFF);
      chk("R8", "no irq", {31'd0, irq}, 32'd0);
      // R6: expiry coinciding with a same-state write
      cycle(1'b1, 32'h8000_0000, 1'b0, "R3");
      cycle(1'b1, 32'd2, 1'b0, "R2");
      cycle(1'b0, '0, 1'b1, "R5");
      cycle(1'b1, 32'd6, 1'b1, "R6");
      chk("R6", "written reload", {1'b0, cur_rd}, 32'd6);
      chk("R6", "irq with write", {31'd0, irq}, 32'd1);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic we, tk;
         logic [DW-1:0] d;
         we = ($urandom_range(0, 9) < 2);
         tk = ($urandom_range(0, 9) < 7);
         d[DW-1] = $urandom_range(0, 1) == 1;
         d[CW-1:0] = ($urandom_range(0, 9) == 0) ? CW'($urandom) : CW'($urandom_range(0, 9));
         cycle(we, d, tk, m_irq ? "R6" : "R5");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule